// File: doc/BRIEF.md
# Keyed External Reset Pulse Generator

This block generates the pulse that a watchdog sends to other devices when its timer runs out. A configuration word holds three things: a pulse-length field, an output polarity bit and an output drive-mode bit. Every write updates the length field from the low bits of the written word. The polarity and drive-mode bits change only when the top byte of the written word is one of four key values. Because of this, software can rewrite the length freely without disturbing the pad configuration, and a stray write cannot flip the pad configuration.

A one-cycle trigger from the watchdog counter starts a pulse. The pulse lasts the programmed field value plus one microsecond ticks, where one tick is `CLKS_PER_US` clock cycles. The block drives a pad value and a pad enable. With the enable the pad can behave as a push-pull driver or as an open-drain driver. A trigger that arrives during a pulse starts the count again. The new count uses the field value that is current at that trigger.

Top module: `keyed_reset_pulser`

## Requirements
- R1: After reset the polarity bit is 0 (active low), the drive-mode bit is 0 (open-drain), the length field is 0xFF, no pulse runs, and the read word is 0x000000FF.
- R2: Every write loads the length field from write bits DUR_W-1:0, whatever the top byte holds. The read word shows the field in bits DUR_W-1:0 and zero in bits 29:DUR_W.
- R3: A write whose top byte (bits 31:24) is 0xA5 sets the polarity bit (active high). A top byte of 0x5A clears it. The read word shows the polarity in bit 31.
- R4: A write whose top byte is 0xA8 sets the drive-mode bit (push-pull). A top byte of 0x8A clears it (open-drain). The read word shows the drive mode in bit 30.
- R5: A write with any other top byte leaves both the polarity bit and the drive-mode bit unchanged.
- R6: A trigger sampled at a clock edge makes `pulse_active` high from that edge onward for exactly (field+1)*CLKS_PER_US cycles.
- R7: A trigger during a running pulse restarts the count from zero. The new length uses the field value held at that trigger.
- R8: A write made while a pulse runs does not change the length of that pulse.
- R9: In open-drain mode, `pad_oe` equals `pulse_active` and `pad_o` equals the polarity bit (the active level).
- R10: In push-pull mode, `pad_oe` is always 1. `pad_o` shows the active level during a pulse and the inverse level when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Write word: key byte in 31:24, length in DUR_W-1:0 |
| rd_data | output | 32 | Read word: polarity 31, drive mode 30, length low bits |
| trigger | input | 1 | One-cycle pulse start request |
| pulse_active | output | 1 | High while a pulse runs |
| pad_o | output | 1 | Pad output level |
| pad_oe | output | 1 | Pad output enable |

## Verification
The assertions check on every cycle that:
- the pad enable and level follow the drive-mode rules;
- the polarity and drive-mode bits hold through idle cycles and through writes that carry no matching key;
- a trigger always starts a pulse at its first tick;
- a pulse never runs past its latched length.

Only the bench's scenarios can show the following. It measures the exact pulse length in cycles for several field values. It checks the restart on a retrigger and confirms that the length latched at the trigger survives a write during the pulse. It also compares the whole read word against a model over a random sequence of writes that mixes keys and plain bytes.

// File: rtl/kp_pkg.sv
package kp_pkg;

    localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
    localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
    localparam logic [7:0] KEY_PUSH     = 8'hA8;
    localparam logic [7:0] KEY_DRAIN    = 8'h8A;

    typedef enum logic [2:0] {
        KEY_NONE,
        KEY_SET_HIGH,
        KEY_SET_LOW,
        KEY_SET_PUSH,
        KEY_SET_DRAIN
    } key_e;

    function automatic key_e decode_key(input logic [7:0] top);
        case (top)
            KEY_POL_HIGH: return KEY_SET_HIGH;
            KEY_POL_LOW:  return KEY_SET_LOW;
            KEY_PUSH:     return KEY_SET_PUSH;
            KEY_DRAIN:    return KEY_SET_DRAIN;
            default:      return KEY_NONE;
        endcase
    endfunction

endpackage

// File: rtl/kp_cfg_reg.sv
module kp_cfg_reg
    import kp_pkg::*;
#(
    parameter int DUR_W     = 20,
    parameter int DUR_RESET = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic             pol_high,
    output logic             push_pull,
    output logic [DUR_W-1:0] dur_field,
    output logic [31:0]      rd_word
);

    localparam int PAD_W = 30 - DUR_W;

    typedef struct packed {
        logic             pol;
        logic             pp;
        logic [DUR_W-1:0] dur;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    key_e key;

    always_comb begin
        key   = decode_key(wr_data[31:24]);
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.dur = wr_data[DUR_W-1:0];
            case (key)
                KEY_SET_HIGH:  cfg_d.pol = 1'b1;
                KEY_SET_LOW:   cfg_d.pol = 1'b0;
                KEY_SET_PUSH:  cfg_d.pp  = 1'b1;
                KEY_SET_DRAIN: cfg_d.pp  = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.pol <= 1'b0;
            cfg_q.pp  <= 1'b0;
            cfg_q.dur <= DUR_W'(DUR_RESET);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign pol_high  = cfg_q.pol;
    assign push_pull = cfg_q.pp;
    assign dur_field = cfg_q.dur;
    assign rd_word   = {cfg_q.pol, cfg_q.pp, {PAD_W{1'b0}}, cfg_q.dur};

    assert_pol_needs_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || (wr_data[31:24] != KEY_POL_HIGH && wr_data[31:24] != KEY_POL_LOW))
        |=> $stable(pol_high));

    assert_mode_needs_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || (wr_data[31:24] != KEY_PUSH && wr_data[31:24] != KEY_DRAIN))
        |=> $stable(push_pull));

    assert_high_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] == KEY_POL_HIGH) |=> rd_word[31]);

    assert_drain_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] == KEY_DRAIN) |=> !rd_word[30]);

endmodule

// File: rtl/kp_pulse_timer.sv
module kp_pulse_timer #(
    parameter int DUR_W       = 20,
    parameter int CLKS_PER_US = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trigger,
    input  logic [DUR_W-1:0] dur_field,
    output logic             active
);

    localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);

    typedef struct packed {
        logic             act;
        logic [PRE_W-1:0] pre;
        logic [DUR_W-1:0] ticks;
        logic [DUR_W-1:0] limit;
    } tmr_t;

    tmr_t t_d, t_q;
    logic tick_end;

    always_comb begin
        t_d      = t_q;
        tick_end = (t_q.pre == PRE_LAST);
        if (trigger) begin
            t_d.act   = 1'b1;
            t_d.pre   = '0;
            t_d.ticks = '0;
            t_d.limit = dur_field;
        end else if (t_q.act) begin
            if (tick_end) begin
                t_d.pre = '0;
                if (t_q.ticks == t_q.limit) begin
                    t_d.act   = 1'b0;
                    t_d.ticks = '0;
                end else begin
                    t_d.ticks = t_q.ticks + 1'b1;
                end
            end else begin
                t_d.pre = t_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign active = t_q.act;

    assert_trigger_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> (active && t_q.ticks == '0 && t_q.pre == '0));

    assert_retrigger_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> (t_q.limit == $past(dur_field)));

    assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (t_q.ticks <= t_q.limit && t_q.pre <= PRE_LAST));

    assert_ends_at_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !trigger && t_q.ticks == t_q.limit && t_q.pre == PRE_LAST) |=> !active);

    assert_limit_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !trigger) |=> $stable(t_q.limit));

endmodule

// File: rtl/kp_pad_stage.sv
module kp_pad_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic pol_high,
    input  logic push_pull,
    output logic pad_o,
    output logic pad_oe
);

    always_comb begin
        if (push_pull) begin
            pad_oe = 1'b1;
            pad_o  = active ? pol_high : !pol_high;
        end else begin
            pad_oe = active;
            pad_o  = pol_high;
        end
    end

    assert_drain_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !push_pull |-> (pad_oe == active && pad_o == pol_high));

    assert_push_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push_pull |-> (pad_oe && (pad_o == (active ~^ pol_high))));

endmodule

// File: rtl/keyed_reset_pulser.sv
module keyed_reset_pulser #(
    parameter int DUR_W       = 20,
    parameter int CLKS_PER_US = 100,
    parameter int DUR_RESET   = 255
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        trigger,
    output logic        pulse_active,
    output logic        pad_o,
    output logic        pad_oe
);

    logic             pol_high;
    logic             push_pull;
    logic [DUR_W-1:0] dur_field;

    kp_cfg_reg #(.DUR_W(DUR_W), .DUR_RESET(DUR_RESET)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .pol_high(pol_high), .push_pull(push_pull), .dur_field(dur_field),
        .rd_word(rd_data)
    );

    kp_pulse_timer #(.DUR_W(DUR_W), .CLKS_PER_US(CLKS_PER_US)) tmr_i (
        .clk(clk), .rst_n(rst_n), .trigger(trigger), .dur_field(dur_field),
        .active(pulse_active)
    );

    kp_pad_stage pad_i (
        .clk(clk), .rst_n(rst_n), .active(pulse_active), .pol_high(pol_high),
        .push_pull(push_pull), .pad_o(pad_o), .pad_oe(pad_oe)
    );

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n)) |-> !pulse_active);

endmodule

// File: tb/keyed_reset_pulser_tb.sv
module keyed_reset_pulser_tb_top;

    localparam int W   = 20;
    localparam int CPU = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        trigger = 1'b0;
    logic [31:0] rd_data;
    logic        pulse_active, pad_o, pad_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic          m_pol = 1'b0, m_pp = 1'b0;
    logic [W-1:0]  m_dur = W'(255);

    always #5 clk = ~clk;

    keyed_reset_pulser #(.DUR_W(W), .CLKS_PER_US(CPU), .DUR_RESET(255)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .trigger(trigger), .pulse_active(pulse_active),
        .pad_o(pad_o), .pad_oe(pad_oe)
    );

    function automatic logic [31:0] exp_word();
        return {m_pol, m_pp, {(30-W){1'b0}}, m_dur};
    endfunction

    function automatic logic exp_oe(input logic act);
        return m_pp ? 1'b1 : act;
    endfunction

    function automatic logic exp_o(input logic act);
        return m_pp ? (act ? m_pol : !m_pol) : m_pol;
    endfunction

    task automatic model_write(input logic [31:0] d);
        m_dur = d[W-1:0];
        case (d[31:24])
            8'hA5: m_pol = 1'b1;
            8'h5A: m_pol = 1'b0;
            8'hA8: m_pp  = 1'b1;
            8'h8A: m_pp  = 1'b0;
            default: ;
        endcase
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        model_write(d);
        @(negedge clk);
    endtask

    // Fires a trigger and counts the cycles pulse_active stays high. Optional
    // mid-pulse write (at count wr_at) and retrigger (at count rt_at).
    task automatic measure(input string req, input int expected,
                           input int wr_at, input logic [31:0] wr_d,
                           input int rt_at);
        int  cnt = 0;
        bit  pad_bad = 1'b0;
        @(posedge clk); #1;
        trigger = 1'b1;
        @(posedge clk); #1;
        trigger = 1'b0;
        @(negedge clk);
        while (pulse_active && cnt < 100000) begin
            if (pad_oe !== exp_oe(1'b1) || pad_o !== exp_o(1'b1)) pad_bad = 1'b1;
            cnt++;
            wr_en = 1'b0;
            trigger = 1'b0;
            if (cnt == wr_at) begin
                wr_en = 1'b1; wr_data = wr_d;
            end
            if (cnt == rt_at) trigger = 1'b1;
            @(negedge clk);
            if (cnt == wr_at) model_write(wr_d);
        end
        wr_en = 1'b0;
        trigger = 1'b0;
        check(req, cnt, expected);
        check("R9/R10 pad during pulse", {31'd0, pad_bad}, 32'd0);
        check("R9/R10 pad idle", {30'd0, pad_oe, pad_o}, {30'd0, exp_oe(1'b0), exp_o(1'b0)});
    endtask

    initial begin
        #1_900_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 read word", rd_data, 32'h0000_00FF);
        check("R1 idle pins", {29'd0, pulse_active, pad_oe, pad_o}, 32'd0);

        // R6 default length 256 us
        measure("R6 default length", 256 * CPU, -1, '0, -1);

        // R2 field write with plain top byte
        do_write(32'h1200_0003);
        check("R2 field write", rd_data, exp_word());
        measure("R6 length field 3", 4 * CPU, -1, '0, -1);

        // R3 polarity keys
        do_write(32'hA500_0000);
        check("R3 set active high", rd_data, exp_word());
        measure("R6 length field 0", CPU, -1, '0, -1);
        do_write(32'h5A00_0002);
        check("R3 set active low", rd_data, exp_word());

        // R4 drive mode keys, R10 push-pull pad
        do_write(32'hA800_0001);
        check("R4 set push-pull", rd_data, exp_word());
        check("R10 idle pad", {30'd0, pad_oe, pad_o}, {30'd0, 1'b1, 1'b1});
        measure("R6 push-pull length", 2 * CPU, -1, '0, -1);
        do_write(32'hA500_0001);
        measure("R10 active-high push-pull", 2 * CPU, -1, '0, -1);
        do_write(32'h8A00_0001);
        check("R4 set open-drain", rd_data, exp_word());

        // R5 near-miss key bytes
        do_write(32'hA400_0005);
        check("R5 near key A4", rd_data, exp_word());
        do_write(32'h8B00_0006);
        check("R5 near key 8B", rd_data, exp_word());

        // R2 max field readback
        do_write(32'h00FF_FFFF);
        check("R2 upper bits zero", rd_data, exp_word());

        // R8 write during pulse does not alter length
        do_write(32'h0000_0004);
        measure("R8 write mid pulse", 5 * CPU, 7, 32'h0000_0001, -1);
        check("R8 new field stored", rd_data, exp_word());

        // R7 retrigger restarts with the field current at retrigger
        do_write(32'h0000_0005);
        measure("R7 retrigger", 13 + 3 * CPU, 4, 32'h0000_0002, 13);

        // Random writes and pulses
        for (int i = 0; i < 40; i++) begin
            logic [31:0] d;
            int sel;
            sel = $urandom % 6;
            d = $urandom;
            case (sel)
                0: d[31:24] = 8'hA5;
                1: d[31:24] = 8'h5A;
                2: d[31:24] = 8'hA8;
                3: d[31:24] = 8'h8A;
                default: ;
            endcase
            d[W-1:0] = W'($urandom % 6);
            do_write(d);
            check("R2/R3/R4/R5 random write", rd_data, exp_word());
            if (i % 4 == 0)
                measure("R6 random length", (int'(m_dur) + 1) * CPU, -1, '0, -1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule